// File: doc/BRIEF.md
# Adapter Host Command and Status Controller

This block is the control core that a host driver talks to in a small network adapter. The host writes 16-bit command words into a single write-only port. Each word holds a 5-bit opcode and an 11-bit argument. A 16-bit status word can be read back at any time. It shows the selected register window, a busy flag and a byte of latched interrupt causes.

The block keeps several pieces of state:
- the current window;
- the latched cause bits, which are set by event inputs and cleared bit by bit with an acknowledge command;
- a programmable interrupt mask;
- a read mask that filters the cause byte shown in status;
- enable flags for the receive path, the transmit path and statistics gathering.

The event inputs stand in for the datapath, FIFO and EEPROM sources, which live elsewhere. A global-reset command restores every register and holds the busy flag high for a fixed number of cycles. Commands written while the busy flag is high are dropped.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: A command word is split into opcode `cmd_word[15:11]` and argument `cmd_word[10:0]`. The status word is laid out as follows: `[15:13]` current window, `[12]` busy, `[11:8]` always zero, `[7:0]` latched causes ANDed with the read mask.
- R2: Opcode 1 loads the window from argument bits `[2:0]`; higher argument bits are ignored. The new window shows in status from the clock edge that takes the command.
- R3: After reset the receive, transmit and statistics enables are all 0. Opcode 4 sets the receive enable and opcode 3 clears it. Opcode 9 sets the transmit enable and opcode 10 clears it. Opcode 21 sets the statistics enable and opcode 22 clears it.
- R4: Event input bits 1..5 and 7 set the matching cause bit at the next clock edge. Event bits 0 and 6 have no effect. Opcode 12 sets cause bit 6.
- R5: Opcode 13 clears each cause bit whose argument bit (0..7) is 1. A set request to the same bit in the same cycle wins over the clear.
- R6: Opcode 14 loads the interrupt mask from argument bits `[7:0]`; its reset value is 0x00. `irq_o` is high whenever any cause bit in 1..7 is set together with its mask bit.
- R7: Cause bit 0 is set at the clock edge after any cycle in which `irq_o` is high. It stays set until it is acknowledged.
- R8: Opcode 15 loads the read mask from argument bits `[7:0]`; its reset value is 0xFF. The read mask changes only the status byte and never `irq_o`.
- R9: Opcode 0 returns the window, the enables, the cause bits and both masks to their reset values at the edge that takes it. The busy flag is then high for exactly `RST_CYCLES` cycles.
- R10: A command written while the busy flag is high has no effect.
- R11: Every opcode not listed above raises the busy flag for exactly one cycle and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe, one word per cycle |
| cmd_word | input | 16 | Command word: opcode and argument |
| evt_i | input | 8 | Cause event requests, one bit per cause |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receive path enable |
| tx_en_o | output | 1 | Transmit path enable |
| stats_en_o | output | 1 | Statistics enable |

## Verification
The assertions run on every cycle and check the following:
- a window command lands in the window register;
- an unknown opcode raises busy;
- a global reset clears state and raises busy;
- an acknowledged cause bit drops unless it is re-requested;
- a high interrupt is followed by cause bit 0;
- event inputs set their cause bits;
- a command written while busy leaves the window and enables unchanged.

Other properties can only be shown by the directed scenarios:
- the exact length of the busy window after a global reset;
- the read mask hiding causes without touching the interrupt;
- the masking of individual sources;
- the inert event bits 0 and 6;
- the full status word layout.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;

    localparam int OP_W  = 5;
    localparam int ARG_W = 11;
    localparam int CMD_W = OP_W + ARG_W;
    localparam int WIN_W = 3;
    localparam int SRC_W = 8;
    localparam int RSV_W = CMD_W - WIN_W - 1 - SRC_W;

    // cause bit positions with special set sources
    localparam int SRC_LATCH = 0;
    localparam int SRC_REQ   = 6;

    localparam logic [OP_W-1:0] OPC_GRST      = 5'd0;
    localparam logic [OP_W-1:0] OPC_WIN       = 5'd1;
    localparam logic [OP_W-1:0] OPC_RX_OFF    = 5'd3;
    localparam logic [OP_W-1:0] OPC_RX_ON     = 5'd4;
    localparam logic [OP_W-1:0] OPC_TX_ON     = 5'd9;
    localparam logic [OP_W-1:0] OPC_TX_OFF    = 5'd10;
    localparam logic [OP_W-1:0] OPC_REQ_INT   = 5'd12;
    localparam logic [OP_W-1:0] OPC_ACK       = 5'd13;
    localparam logic [OP_W-1:0] OPC_SET_IMASK = 5'd14;
    localparam logic [OP_W-1:0] OPC_SET_RMASK = 5'd15;
    localparam logic [OP_W-1:0] OPC_STAT_ON   = 5'd21;
    localparam logic [OP_W-1:0] OPC_STAT_OFF  = 5'd22;

    typedef struct packed {
        logic             grst;
        logic             win;
        logic             rx_on;
        logic             rx_off;
        logic             tx_on;
        logic             tx_off;
        logic             st_on;
        logic             st_off;
        logic             req_int;
        logic             ack;
        logic             set_imask;
        logic             set_rmask;
        logic             unknown;
        logic [ARG_W-1:0] arg;
    } cmd_dec_t;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             busy;
        logic [RSV_W-1:0] rsvd;
        logic [SRC_W-1:0] cause;
    } status_t;

    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] w, input logic en);
        cmd_dec_t d;
        d     = '0;
        d.arg = w[ARG_W-1:0];
        if (en) begin
            case (w[CMD_W-1:ARG_W])
                OPC_GRST:      d.grst      = 1'b1;
                OPC_WIN:       d.win       = 1'b1;
                OPC_RX_OFF:    d.rx_off    = 1'b1;
                OPC_RX_ON:     d.rx_on     = 1'b1;
                OPC_TX_ON:     d.tx_on     = 1'b1;
                OPC_TX_OFF:    d.tx_off    = 1'b1;
                OPC_REQ_INT:   d.req_int   = 1'b1;
                OPC_ACK:       d.ack       = 1'b1;
                OPC_SET_IMASK: d.set_imask = 1'b1;
                OPC_SET_RMASK: d.set_rmask = 1'b1;
                OPC_STAT_ON:   d.st_on     = 1'b1;
                OPC_STAT_OFF:  d.st_off    = 1'b1;
                default:       d.unknown   = 1'b1;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
    import nic_ctl_pkg::*;
(
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             busy,
    output cmd_dec_t         dec
);
    // a command is taken only when the strobe is high and the block is idle
    always_comb begin
        dec = decode_cmd(cmd_word, cmd_wr && !busy);
    end
endmodule

// File: rtl/nic_ctl_state.sv
module nic_ctl_state
    import nic_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  cmd_dec_t         dec,
    output logic [WIN_W-1:0] win_o,
    output logic             rx_en_o,
    output logic             tx_en_o,
    output logic             st_en_o,
    output logic             busy_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_o    <= '0;
            rx_en_o  <= 1'b0;
            tx_en_o  <= 1'b0;
            st_en_o  <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (dec.grst) begin
                win_o    <= '0;
                rx_en_o  <= 1'b0;
                tx_en_o  <= 1'b0;
                st_en_o  <= 1'b0;
                busy_cnt <= CW'(RST_CYCLES);
            end
            if (dec.unknown) busy_cnt <= CW'(1);
            if (dec.win)     win_o    <= dec.arg[WIN_W-1:0];
            if (dec.rx_on)   rx_en_o  <= 1'b1;
            if (dec.rx_off)  rx_en_o  <= 1'b0;
            if (dec.tx_on)   tx_en_o  <= 1'b1;
            if (dec.tx_off)  tx_en_o  <= 1'b0;
            if (dec.st_on)   st_en_o  <= 1'b1;
            if (dec.st_off)  st_en_o  <= 1'b0;
        end
    end

    assign busy_o = (busy_cnt != '0);

    p_win_load_r2: assert property (@(posedge clk) disable iff (rst)
        dec.win |=> (win_o == $past(dec.arg[WIN_W-1:0])));

    p_unknown_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        dec.unknown |=> busy_o);

    p_grst_state_r9: assert property (@(posedge clk) disable iff (rst)
        dec.grst |=> (busy_o && win_o == '0 && !rx_en_o && !tx_en_o && !st_en_o));
endmodule

// File: rtl/nic_irq_core.sv
module nic_irq_core
    import nic_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_dec_t         dec,
    input  logic [SRC_W-1:0] evt_i,
    output logic [SRC_W-1:0] cause_o,
    output logic [SRC_W-1:0] rmask_o,
    output logic             irq_o
);
    logic [SRC_W-1:0] imask_q;
    logic [SRC_W-1:0] set_v;
    logic [SRC_W-1:0] clr_v;

    assign irq_o = |(cause_o[SRC_W-1:1] & imask_q[SRC_W-1:1]);

    always_ff @(posedge clk) begin
        if (rst || dec.grst) begin
            imask_q <= '0;
            rmask_o <= '1;
        end else begin
            if (dec.set_imask) imask_q <= dec.arg[SRC_W-1:0];
            if (dec.set_rmask) rmask_o <= dec.arg[SRC_W-1:0];
        end
    end

    for (genvar i = 0; i < SRC_W; i++) begin : g_cause
        if (i == SRC_LATCH) begin : g_latch
            assign set_v[i] = irq_o;
        end else if (i == SRC_REQ) begin : g_req
            assign set_v[i] = dec.req_int;
        end else begin : g_evt
            assign set_v[i] = evt_i[i];
        end
        assign clr_v[i] = dec.ack && dec.arg[i];

        always_ff @(posedge clk) begin
            if (rst || dec.grst)  cause_o[i] <= 1'b0;
            else if (set_v[i])    cause_o[i] <= 1'b1;
            else if (clr_v[i])    cause_o[i] <= 1'b0;
        end

        p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (clr_v[i] && !set_v[i]) |=> !cause_o[i]);

        p_set_sticks_r4: assert property (@(posedge clk) disable iff (rst)
            (set_v[i] && !dec.grst) |=> cause_o[i]);
    end

    p_latch0_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !dec.grst) |=> cause_o[SRC_LATCH]);
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
    import nic_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 16
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_word,
    input  logic [7:0]  evt_i,
    output logic [15:0] status_o,
    output logic        irq_o,
    output logic        rx_en_o,
    output logic        tx_en_o,
    output logic        stats_en_o
);
    cmd_dec_t         dec;
    logic             busy;
    logic [WIN_W-1:0] win;
    logic [SRC_W-1:0] cause;
    logic [SRC_W-1:0] rmask;
    status_t          stat;

    nic_cmd_decode u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .busy     (busy),
        .dec      (dec)
    );

    nic_ctl_state #(.RST_CYCLES(RST_CYCLES)) u_state (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .win_o   (win),
        .rx_en_o (rx_en_o),
        .tx_en_o (tx_en_o),
        .st_en_o (stats_en_o),
        .busy_o  (busy)
    );

    nic_irq_core u_irq (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec),
        .evt_i   (evt_i),
        .cause_o (cause),
        .rmask_o (rmask),
        .irq_o   (irq_o)
    );

    always_comb begin
        stat.win   = win;
        stat.busy  = busy;
        stat.rsvd  = '0;
        stat.cause = cause & rmask;
    end
    assign status_o = stat;

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> ($stable(status_o[15:13]) && $stable(rx_en_o)
                              && $stable(tx_en_o) && $stable(stats_en_o)));
endmodule

// File: tb/nic_cmd_ctrl_tb.sv
module nic_cmd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  evt_i = '0;
    logic [15:0] status_o;
    logic        irq_o, rx_en_o, tx_en_o, stats_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_cmd_ctrl #(.RST_CYCLES(RST_CYC)) dut_i (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .evt_i(evt_i),
        .status_o(status_o), .irq_o(irq_o), .rx_en_o(rx_en_o),
        .tx_en_o(tx_en_o), .stats_en_o(stats_en_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the taking edge
    task automatic send(input logic [4:0] op, input logic [10:0] arg);
        cmd_word = {op, arg};
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] v);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset status", status_o, 16'h0000);
        chk("R3 reset enables", {13'b0, rx_en_o, tx_en_o, stats_en_o}, 16'h0);
        chk("R6 reset irq", {15'b0, irq_o}, 16'h0);
    endtask

    task automatic t_window();
        send(5'd1, 11'h7F5);
        chk("R2 window 5 high arg ignored", status_o, 16'hA000);
        send(5'd1, 11'h002);
        chk("R1 window field position", status_o, 16'h4000);
    endtask

    task automatic t_enables();
        send(5'd4, 11'h0);
        send(5'd9, 11'h0);
        send(5'd21, 11'h0);
        chk("R3 all enabled", {13'b0, rx_en_o, tx_en_o, stats_en_o}, 16'h7);
        send(5'd3, 11'h0);
        chk("R3 rx off", {13'b0, rx_en_o, tx_en_o, stats_en_o}, 16'h3);
        send(5'd10, 11'h0);
        send(5'd22, 11'h0);
        chk("R3 all off", {13'b0, rx_en_o, tx_en_o, stats_en_o}, 16'h0);
    endtask

    task automatic t_events();
        pulse(8'hFF);
        chk("R4 events latch 1-5,7", {8'h0, status_o[7:0]}, 16'h00BE);
        send(5'd13, 11'h0FF);
        chk("R5 ack all", {8'h0, status_o[7:0]}, 16'h0);
        pulse(8'h41);
        chk("R4 evt bits 0 and 6 inert", {8'h0, status_o[7:0]}, 16'h0);
        send(5'd12, 11'h0);
        chk("R4 request sets bit 6", {8'h0, status_o[7:0]}, 16'h0040);
        send(5'd13, 11'h040);
        pulse(8'h0C);
        send(5'd13, 11'h004);
        chk("R5 ack clears only bit 2", {8'h0, status_o[7:0]}, 16'h0008);
        evt_i = 8'h08;
        send(5'd13, 11'h008);
        evt_i = 8'h00;
        chk("R5 event wins over ack", {8'h0, status_o[7:0]}, 16'h0008);
        send(5'd13, 11'h008);
        chk("R5 ack after race", {8'h0, status_o[7:0]}, 16'h0);
    endtask

    task automatic t_irq();
        send(5'd14, 11'h010);
        pulse(8'h04);
        chk("R6 masked source no irq", {15'b0, irq_o}, 16'h0);
        pulse(8'h10);
        chk("R6 unmasked source irq", {15'b0, irq_o}, 16'h1);
        chk("R7 bit0 not yet set", {8'h0, status_o[7:0]}, 16'h0014);
        @(negedge clk);
        chk("R7 bit0 follows irq", {8'h0, status_o[7:0]}, 16'h0015);
        send(5'd13, 11'h010);
        chk("R6 irq drops on ack", {15'b0, irq_o}, 16'h0);
        chk("R7 bit0 stays until acked", {8'h0, status_o[7:0]}, 16'h0005);
        send(5'd13, 11'h005);
        chk("R7 bit0 ack", {8'h0, status_o[7:0]}, 16'h0);
    endtask

    task automatic t_rdmask();
        pulse(8'h22);
        send(5'd15, 11'h002);
        chk("R8 read mask filters", {8'h0, status_o[7:0]}, 16'h0002);
        send(5'd14, 11'h020);
        chk("R8 irq on hidden cause", {15'b0, irq_o}, 16'h1);
        send(5'd15, 11'h000);
        chk("R8 zero read mask irq kept", {7'b0, irq_o, status_o[7:0]}, 16'h0100);
        send(5'd15, 11'h0FF);
        chk("R8 full read mask", {8'h0, status_o[7:0]}, 16'h0023);
        send(5'd13, 11'h023);
        send(5'd13, 11'h001);
        send(5'd14, 11'h000);
        chk("R8 clean after", {7'b0, irq_o, status_o[7:0]}, 16'h0);
    endtask

    task automatic t_greset();
        int n;
        send(5'd1, 11'h003);
        send(5'd4, 11'h0);
        send(5'd14, 11'h0FF);
        send(5'd15, 11'h00F);
        pulse(8'h02);
        send(5'd0, 11'h0);
        chk("R9 state after global reset", status_o, 16'h1000);
        chk("R9 enables and irq cleared", {12'b0, irq_o, rx_en_o, tx_en_o, stats_en_o}, 16'h0);
        send(5'd4, 11'h0);
        send(5'd1, 11'h006);
        n = 0;
        while (status_o[12] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R9 busy length", 16'(n + 2), 16'(RST_CYC));
        chk("R10 commands dropped while busy", {status_o[15:13], 12'b0, rx_en_o}, 16'h0);
        pulse(8'h02);
        chk("R9 masks restored", {7'b0, irq_o, status_o[7:0]}, 16'h0002);
        send(5'd13, 11'h002);
    endtask

    task automatic t_unknown();
        send(5'd1, 11'h001);
        send(5'd5, 11'h7FF);
        chk("R11 unknown busy pulse", status_o, 16'h3000);
        send(5'd4, 11'h0);
        chk("R10 dropped during pulse", {status_o[15:12], 11'b0, rx_en_o}, 16'h2000);
        send(5'd31, 11'h0);
        @(negedge clk);
        chk("R11 opcode 31 no effect", status_o, 16'h2000);
        send(5'd4, 11'h0);
        chk("R11 idle again accepts", {15'b0, rx_en_o}, 16'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_window();
        t_enables();
        t_events();
        t_irq();
        t_rdmask();
        t_greset();
        t_unknown();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule